// File: doc/BRIEF.md
# Instrument Status Byte Reporting Unit

This block keeps the two status registers that a bus-attached instrument shows to its host. The first is an event register that latches one-cycle event strobes. Examples are power-on, command error and value adapted. The second is a status byte that summarises the instrument's state. The block also holds two masks. The event enable mask selects which latched events feed the event summary bit. The service enable mask selects which status byte bits can raise a service request. The host reaches the block through a 3-bit decoded operation code and an 8-bit write data bus. Read results appear on a registered data port one cycle after the operation.

The status byte has two read paths, and they differ in bit 6 and in what they clear. A query returns the live master summary in bit 6. It then clears the latched status bits and the request flag. A serial poll returns the latched request flag in bit 6 and clears only that flag. The request flag and the service request line are one and the same. A two-state machine drives them: `SRQ_IDLE` and `SRQ_ASSERTED`. The transition IDLE→ASSERTED is taken on a rising edge of the master summary. The transition ASSERTED→IDLE is taken on a query, a serial poll or a clear-all, unless a new rising edge arrives in the same cycle.

Top module: `status_report_unit`

## Requirements
- R1: After reset the event register holds 0x0080 (the power-on bit, bit 7), both enable masks are zero, the latched status bits are zero and `srq_o` is low.
- R2: Event register bits 7..0 are set by pulses on `esr_evt_i` and stay set until cleared, so a command error (bit 5) is latched again on every occurrence. Bits 15..8 always read as zero.
- R3: Operation 2 (event query) returns the event register value from before the read on `rd_data_o`, with `rd_valid_o` high in the next cycle, and clears the register. For example, power-on followed by a command error reads as 160 (0x00A0).
- R4: Status byte bit 4 follows `mav_i` live. Bit 5 is the OR over all event register bits ANDed with the event enable mask.
- R5: Status byte bits 0, 1, 2 (value adapted), 3 and 7 are latched from pulses on `stb_evt_i`. Pulses on `stb_evt_i` bits 4, 5 and 6 have no effect.
- R6: The master summary is the OR of status byte bits 0–5 and 7, each ANDed with the service enable mask. `srq_o` rises one cycle after a rising edge of the master summary.
- R7: Operation 1 (status query) returns the status byte with bit 6 equal to the master summary. It then clears the latched status bits and drops `srq_o`.
- R8: Operation 4 (serial poll) returns the status byte with bit 6 equal to the request flag (`srq_o`). It clears only that flag, and all other status bits stay as they were.
- R9: Operation 3 (clear-all) clears the event register, the latched status bits and the request flag. It returns no read data and leaves both enable masks unchanged.
- R10: Operation 5 loads the event enable mask and operation 6 loads the service enable mask, both from `wr_data_i`. Bit 6 of the service enable mask is forced to zero.
- R11: An event pulse in the same cycle as a clearing operation is kept. The read data shows the value from before that cycle.
- R12: Operation codes 0 and 7 change no state and return no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| esr_evt_i | input | 8 | Event strobes, one per event register bit |
| stb_evt_i | input | 8 | Status byte event strobes (bits 0,1,2,3,7 used) |
| mav_i | input | 1 | Output queue not empty |
| host_op_i | input | 3 | Decoded host operation code |
| wr_data_i | input | 8 | Mask data for operations 5 and 6 |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Read data |
| srq_o | output | 1 | Service request line |

## Verification
The event register, the stored status bits and the masks have no direct visibility. A wrong value in any of them shows on the first query or poll that follows. A wrong mask also shows on `srq_o` within two cycles of the strobe, because the request line follows the summary after one register stage. If the request state machine is left in the wrong state, a serial poll exposes it through bit 6. The line also either fails to drop after a clear or fails to rise on the next summary edge. The checks therefore pair each strobe with a read one cycle later and check the request line at its exact cycle.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int STB_W    = 8;
    localparam int STB_MAV  = 4;
    localparam int STB_ESB  = 5;
    localparam int STB_RQS  = 6;

    typedef enum logic [2:0] {
        OP_NONE        = 3'd0,
        OP_STB_QUERY   = 3'd1,
        OP_ESR_QUERY   = 3'd2,
        OP_CLEAR_ALL   = 3'd3,
        OP_SERIAL_POLL = 3'd4,
        OP_WR_ESE      = 3'd5,
        OP_WR_SRE      = 3'd6,
        OP_RESERVED    = 3'd7
    } host_op_e;

    typedef enum logic {
        SRQ_IDLE     = 1'b0,
        SRQ_ASSERTED = 1'b1
    } srq_state_e;

    typedef struct packed {
        logic clr_esr;
        logic clr_stb;
        logic clr_flag;
        logic rd_stb;
        logic rd_esr;
        logic rd_poll;
        logic wr_ese;
        logic wr_sre;
    } op_dec_t;

endpackage

// File: rtl/sru_event_reg.sv
module sru_event_reg #(
    parameter int ESR_W   = 16,
    parameter int ACT_W   = 8,
    parameter int PON_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACT_W-1:0] evt_i,
    input  logic             clr_i,
    input  logic             ese_wr_i,
    input  logic [ACT_W-1:0] ese_data_i,
    output logic [ESR_W-1:0] esr_o,
    output logic             summary_o
);
    localparam int PAD_W = ESR_W - ACT_W;
    localparam logic [ACT_W-1:0] PON_MASK = {{(ACT_W-1){1'b0}}, 1'b1} << PON_BIT;

    logic [ACT_W-1:0] esr_q;
    logic [ACT_W-1:0] ese_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esr_q <= PON_MASK;
            ese_q <= '0;
        end else begin
            esr_q <= (clr_i ? '0 : esr_q) | evt_i;
            if (ese_wr_i) begin
                ese_q <= ese_data_i;
            end
        end
    end

    always_comb begin
        esr_o     = {{PAD_W{1'b0}}, esr_q};
        summary_o = |(esr_q & ese_q);
    end

    AST_ESR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((esr_q & $past(esr_q)) == $past(esr_q))); // R2

    AST_ESR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((esr_q & ~$past(evt_i)) == '0)); // R3

    AST_ESR_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((esr_q & $past(evt_i)) == $past(evt_i))); // R11

endmodule

// File: rtl/sru_status_byte.sv
module sru_status_byte
    import sru_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STB_W-1:0] evt_i,
    input  logic             clr_i,
    input  logic             mav_i,
    input  logic             esb_i,
    input  logic             sre_wr_i,
    input  logic [STB_W-1:0] sre_data_i,
    output logic [STB_W-1:0] stb_o,
    output logic             mss_o
);
    localparam logic [STB_W-1:0] ONE        = {{(STB_W-1){1'b0}}, 1'b1};
    localparam logic [STB_W-1:0] LIVE_MASK  = (ONE << STB_MAV) | (ONE << STB_ESB) | (ONE << STB_RQS);
    localparam logic [STB_W-1:0] LATCH_MASK = ~LIVE_MASK;
    localparam logic [STB_W-1:0] SRE_MASK   = ~(ONE << STB_RQS);

    logic [STB_W-1:0] stored_q;
    logic [STB_W-1:0] sre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= '0;
            sre_q    <= '0;
        end else begin
            stored_q <= (clr_i ? '0 : stored_q) | (evt_i & LATCH_MASK);
            if (sre_wr_i) begin
                sre_q <= sre_data_i & SRE_MASK;
            end
        end
    end

    always_comb begin
        stb_o          = stored_q;
        stb_o[STB_MAV] = mav_i;
        stb_o[STB_ESB] = esb_i;
        mss_o          = |(stb_o & sre_q);
    end

    AST_STB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stored_q & $past(stored_q)) == $past(stored_q))); // R5

    AST_MSS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mss_o |-> (sre_q != '0)); // R6

    AST_STB_BIT6_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_o[STB_RQS]); // R8

endmodule

// File: rtl/sru_srq_fsm.sv
module sru_srq_fsm
    import sru_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mss_i,
    input  logic clr_i,
    output logic srq_o
);
    srq_state_e state_q, state_d;
    logic       mss_q;
    logic       rise;

    assign rise = mss_i & ~mss_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRQ_IDLE;
            mss_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            mss_q   <= mss_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRQ_IDLE: begin
                if (rise) state_d = SRQ_ASSERTED;
            end
            SRQ_ASSERTED: begin
                if (clr_i && !rise) state_d = SRQ_IDLE;
            end
        endcase
    end

    always_comb begin
        srq_o = (state_q == SRQ_ASSERTED);
    end

    AST_SRQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srq_o) |-> ($past(mss_i) && !$past(mss_q))); // R6

    AST_SRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(mss_i && !mss_q)) |=> !srq_o); // R8

endmodule

// File: rtl/sru_read_port.sv
module sru_read_port
    import sru_pkg::*;
#(
    parameter int ESR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb_i,
    input  logic             rd_poll_i,
    input  logic             rd_esr_i,
    input  logic [STB_W-1:0] stb_i,
    input  logic             mss_i,
    input  logic             flag_i,
    input  logic [ESR_W-1:0] esr_i,
    output logic             rd_valid_o,
    output logic [ESR_W-1:0] rd_data_o
);
    localparam int PAD_W = ESR_W - STB_W;

    logic [STB_W-1:0] stb_view;
    logic [ESR_W-1:0] data_d;

    always_comb begin
        stb_view = stb_i;
        stb_view[STB_RQS] = rd_poll_i ? flag_i : mss_i;
        if (rd_esr_i) begin
            data_d = esr_i;
        end else begin
            data_d = {{PAD_W{1'b0}}, stb_view};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_stb_i | rd_poll_i | rd_esr_i;
            if (rd_stb_i | rd_poll_i | rd_esr_i) begin
                rd_data_o <= data_d;
            end
        end
    end

    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_data_o[ESR_W-1:STB_W] == '0)); // R2

    AST_RD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_stb_i | rd_poll_i | rd_esr_i)); // R12

endmodule

// File: rtl/status_report_unit.sv
module status_report_unit
    import sru_pkg::*;
#(
    parameter int ESR_W = 16,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] esr_evt_i,
    input  logic [STB_W-1:0] stb_evt_i,
    input  logic             mav_i,
    input  logic [2:0]       host_op_i,
    input  logic [STB_W-1:0] wr_data_i,
    output logic             rd_valid_o,
    output logic [ESR_W-1:0] rd_data_o,
    output logic             srq_o
);
    localparam int PON_BIT = EVT_W - 1;

    op_dec_t          dec;
    host_op_e         op;
    logic [ESR_W-1:0] esr;
    logic             esb;
    logic [STB_W-1:0] stb;
    logic             mss;

    assign op = host_op_e'(host_op_i);

    always_comb begin
        dec = '0;
        unique case (op)
            OP_STB_QUERY: begin
                dec.rd_stb   = 1'b1;
                dec.clr_stb  = 1'b1;
                dec.clr_flag = 1'b1;
            end
            OP_ESR_QUERY: begin
                dec.rd_esr  = 1'b1;
                dec.clr_esr = 1'b1;
            end
            OP_CLEAR_ALL: begin
                dec.clr_esr  = 1'b1;
                dec.clr_stb  = 1'b1;
                dec.clr_flag = 1'b1;
            end
            OP_SERIAL_POLL: begin
                dec.rd_poll  = 1'b1;
                dec.clr_flag = 1'b1;
            end
            OP_WR_ESE:   dec.wr_ese = 1'b1;
            OP_WR_SRE:   dec.wr_sre = 1'b1;
            OP_NONE, OP_RESERVED: dec = '0;
        endcase
    end

    sru_event_reg #(
        .ESR_W   (ESR_W),
        .ACT_W   (EVT_W),
        .PON_BIT (PON_BIT)
    ) u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (esr_evt_i),
        .clr_i      (dec.clr_esr),
        .ese_wr_i   (dec.wr_ese),
        .ese_data_i (wr_data_i[EVT_W-1:0]),
        .esr_o      (esr),
        .summary_o  (esb)
    );

    sru_status_byte u_stb (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (stb_evt_i),
        .clr_i      (dec.clr_stb),
        .mav_i      (mav_i),
        .esb_i      (esb),
        .sre_wr_i   (dec.wr_sre),
        .sre_data_i (wr_data_i),
        .stb_o      (stb),
        .mss_o      (mss)
    );

    sru_srq_fsm u_srq (
        .clk   (clk),
        .rst_n (rst_n),
        .mss_i (mss),
        .clr_i (dec.clr_flag),
        .srq_o (srq_o)
    );

    sru_read_port #(
        .ESR_W (ESR_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb_i   (dec.rd_stb),
        .rd_poll_i  (dec.rd_poll),
        .rd_esr_i   (dec.rd_esr),
        .stb_i      (stb),
        .mss_i      (mss),
        .flag_i     (srq_o),
        .esr_i      (esr),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    AST_CLEAR_ALL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR_ALL) |=> !rd_valid_o); // R9

    AST_RESERVED_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESERVED || op == OP_NONE) |=> !rd_valid_o); // R12

endmodule

// File: tb/status_report_unit_tb_top.sv
module status_report_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  esr_evt = '0;
    logic [7:0]  stb_evt = '0;
    logic        mav = 1'b0;
    logic [2:0]  host_op = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        srq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    status_report_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .esr_evt_i  (esr_evt),
        .stb_evt_i  (stb_evt),
        .mav_i      (mav),
        .host_op_i  (host_op),
        .wr_data_i  (wr_data),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data),
        .srq_o      (srq)
    );

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", what, act, exp);
        end
    endtask

    task automatic apply_reset();
        esr_evt = '0; stb_evt = '0; mav = 1'b0; host_op = '0; wr_data = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_op(input logic [2:0] code, input logic [7:0] d);
        host_op = code; wr_data = d;
        @(negedge clk);
        host_op = '0; wr_data = '0;
    endtask

    task automatic read_op(input logic [2:0] code, input string what, input logic [15:0] exp);
        do_op(code, 8'h00);
        check({what, " valid"}, {15'd0, rd_valid}, 16'h0001);
        check(what, rd_data, exp);
    endtask

    task automatic pulse(input logic [7:0] e, input logic [7:0] s);
        esr_evt = e; stb_evt = s;
        @(negedge clk);
        esr_evt = '0; stb_evt = '0;
    endtask

    task automatic t_reset();
        apply_reset();
        check("R1 srq after reset", {15'd0, srq}, 16'h0000);
        check("R1 no read data", {15'd0, rd_valid}, 16'h0000);
        read_op(3'd2, "R1 event reg after reset", 16'h0080);
        read_op(3'd1, "R1 status byte after reset", 16'h0000);
    endtask

    task automatic t_first_read_160();
        apply_reset();
        pulse(8'h20, 8'h00);
        read_op(3'd2, "R3 power-on plus command error", 16'h00A0);
        read_op(3'd2, "R3 cleared by read", 16'h0000);
    endtask

    task automatic t_sticky();
        pulse(8'h20, 8'h00);
        @(negedge clk);
        @(negedge clk);
        read_op(3'd2, "R2 command error held", 16'h0020);
        pulse(8'h20, 8'h00);
        read_op(3'd2, "R2 command error set again", 16'h0020);
        pulse(8'hFF, 8'h00);
        read_op(3'd2, "R2 upper bits zero", 16'h00FF);
    endtask

    task automatic t_event_wins();
        pulse(8'h01, 8'h00);
        esr_evt = 8'h08;
        read_op(3'd2, "R11 event read shows old", 16'h0001);
        esr_evt = '0;
        read_op(3'd2, "R11 event kept", 16'h0008);
        pulse(8'h00, 8'h01);
        stb_evt = 8'h02;
        read_op(3'd1, "R11 status read shows old", 16'h0001);
        stb_evt = '0;
        read_op(3'd1, "R11 status event kept", 16'h0002);
        read_op(3'd1, "R7 status cleared", 16'h0000);
    endtask

    task automatic t_stb_bits();
        mav = 1'b1;
        pulse(8'h00, 8'h70);
        read_op(3'd1, "R5 bits 4-6 ignored, R4 mav live", 16'h0010);
        mav = 1'b0;
        do_op(3'd5, 8'h20);
        pulse(8'h20, 8'h00);
        read_op(3'd1, "R4 event summary bit", 16'h0020);
        read_op(3'd2, "R4 event reg", 16'h0020);
        read_op(3'd1, "R4 summary follows event reg", 16'h0000);
    endtask

    task automatic t_srq_query();
        do_op(3'd6, 8'h04);
        pulse(8'h00, 8'h04);
        check("R6 srq not yet", {15'd0, srq}, 16'h0000);
        @(negedge clk);
        check("R6 srq raised", {15'd0, srq}, 16'h0001);
        read_op(3'd1, "R7 query bit6 is summary", 16'h0044);
        check("R7 srq dropped by query", {15'd0, srq}, 16'h0000);
        read_op(3'd1, "R7 query cleared stored bits", 16'h0000);
    endtask

    task automatic t_poll();
        pulse(8'h00, 8'h04);
        @(negedge clk);
        check("R8 srq raised", {15'd0, srq}, 16'h0001);
        read_op(3'd4, "R8 poll bit6 is flag", 16'h0044);
        check("R8 srq dropped by poll", {15'd0, srq}, 16'h0000);
        read_op(3'd4, "R8 poll flag cleared, bits kept", 16'h0004);
        read_op(3'd1, "R8 summary still set after poll", 16'h0044);
        read_op(3'd1, "R8 cleared by query", 16'h0000);
    endtask

    task automatic t_clear_all();
        pulse(8'h20, 8'h04);
        @(negedge clk);
        check("R9 srq before clear", {15'd0, srq}, 16'h0001);
        do_op(3'd3, 8'h00);
        check("R9 no read data", {15'd0, rd_valid}, 16'h0000);
        check("R9 srq cleared", {15'd0, srq}, 16'h0000);
        read_op(3'd2, "R9 event reg cleared", 16'h0000);
        read_op(3'd1, "R9 status cleared", 16'h0000);
        pulse(8'h20, 8'h00);
        read_op(3'd1, "R9 event enable kept", 16'h0020);
        read_op(3'd2, "R9 event reg", 16'h0020);
    endtask

    task automatic t_sre_bit6();
        do_op(3'd6, 8'h40);
        mav = 1'b1;
        pulse(8'h00, 8'h8F);
        @(negedge clk);
        @(negedge clk);
        check("R10 service enable bit6 ignored", {15'd0, srq}, 16'h0000);
        mav = 1'b0;
        do_op(3'd6, 8'h80);
        @(negedge clk);
        check("R10 service enable write", {15'd0, srq}, 16'h0001);
        read_op(3'd1, "R10 status with summary", 16'h00CF);
        do_op(3'd6, 8'h00);
    endtask

    task automatic t_reserved();
        pulse(8'h04, 8'h00);
        do_op(3'd7, 8'hFF);
        check("R12 op 7 no data", {15'd0, rd_valid}, 16'h0000);
        do_op(3'd0, 8'hFF);
        check("R12 op 0 no data", {15'd0, rd_valid}, 16'h0000);
        read_op(3'd2, "R12 event reg untouched", 16'h0004);
    endtask

    initial begin
        t_reset();
        t_first_read_160();
        t_sticky();
        t_event_wins();
        t_stb_bits();
        t_srq_query();
        t_poll();
        t_clear_all();
        t_sre_bit6();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule